// File: doc/BRIEF.md
# Buffer Command Bus Frame Decoder

This block turns a 4-bit command bus, sampled on each rising clock edge, into complete framed commands for a memory data buffer. A command starts with an opcode slot. The opcode selects how many payload slots follow it. A final parity slot closes the frame. Once the frame is complete the block checks the parity. It then raises a one-cycle command strobe with the command kind and the packed payload, or it raises a one-cycle parity error.

In the first slot, an opcode in the range 0000 to 0111 is a sequence error. The idle code and the two reserved codes start nothing and are always quiet. A clock-enable input freezes the slot counting while it is low. A synchronous clear returns the block to idle with every payload register at zero. The asynchronous active-low reset does the same.

Top module: `cmdbus_frame_decoder`

## Requirements
- R1: After the asynchronous reset, or on the cycle after `sync_clr` is sampled high, the block is idle. `cmd_vld`, `err_par`, `err_seq`, `cmd_kind` and `cmd_payload` all read 0, and a frame that was being collected is dropped.
- R2: Opcode 4'b1000 (write, kind 1) and opcode 4'b1001 (read, kind 2) are each followed by exactly one payload slot and then the parity slot.
- R3: Opcode 4'b1011 (mode-register forward, kind 3) is followed by six payload slots and then the parity slot.
- R4: Opcode 4'b1100 (control-word write, kind 4) is followed by five payload slots and then the parity slot.
- R5: Opcode 4'b1101 (control-word read, kind 5) is followed by four payload slots and then the parity slot.
- R6: When no frame is active, the codes 4'b1010 (idle), 4'b1110 and 4'b1111 (reserved) start no frame and raise no error.
- R7: When no frame is active, a code from 4'b0000 to 4'b0111 raises `err_seq` for one cycle, in the cycle after it is sampled, and starts no frame.
- R8: While a frame is being collected, every slot value is taken as payload, including the idle, reserved and undefined codes.
- R9: The parity slot must equal the bitwise XOR of the opcode and all payload nibbles. On a match, `cmd_vld` is high for one cycle, in the cycle after the parity slot. `cmd_kind` and `cmd_payload` then hold that frame until the next good frame. On a mismatch, `err_par` is high for one cycle instead, `cmd_vld` stays low, and `cmd_kind` and `cmd_payload` keep their previous values.
- R10: A slot sampled while `clk_en` is low is ignored and does not advance the frame. The pulse outputs are still high for only one clock.
- R11: Payload slot i, counted from 0 for the slot right after the opcode, sits in `cmd_payload[4i+3:4i]`. Slots that the opcode does not use read 0.
- R12: A new opcode is accepted in the slot right after a parity slot, so frames may run back to back.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Buffer clock; the bus is sampled on the rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| sync_clr | input | 1 | Synchronous clear back to idle |
| clk_en | input | 1 | Slot qualifier; a slot is consumed only when this is high |
| cmd_nib | input | 4 | Command bus slot value |
| cmd_vld | output | 1 | One-cycle strobe for a good frame |
| cmd_kind | output | 3 | Kind of the last good frame (1 to 5) |
| cmd_payload | output | 24 | Payload of the last good frame, packed by slot |
| err_par | output | 1 | One-cycle parity error pulse |
| err_seq | output | 1 | One-cycle sequence error pulse |

## Verification
Two functions can fall in the same cycle: closing a frame on its parity slot, and the synchronous clear. The bench provokes this by asserting `sync_clr` together with a correct parity slot, and again in the middle of a payload. In both cases it expects no strobe and a block that is cleared on the next cycle. Parity close and opening the next frame also meet when frames run back to back. These cycles are judged by a behavioural model that is compared on every clock. Enable gaps and random slot values run alongside.

// File: rtl/cfd_pkg.sv
package cfd_pkg;
  localparam int NIB_W   = 4;
  localparam int MAX_PAY = 6;
  localparam int CNT_W   = $clog2(MAX_PAY + 1);
  localparam int IDX_W   = $clog2(MAX_PAY);
  localparam int PAY_W   = NIB_W * MAX_PAY;
  localparam int KIND_W  = 3;

  typedef enum logic [KIND_W-1:0] {
    K_NONE = 3'd0,
    K_WR   = 3'd1,
    K_RD   = 3'd2,
    K_MODE = 3'd3,
    K_CWW  = 3'd4,
    K_CWR  = 3'd5
  } cmd_kind_e;

  typedef enum logic [1:0] {
    PH_IDLE    = 2'd0,
    PH_COLLECT = 2'd1,
    PH_CHECK   = 2'd2
  } phase_e;

  function automatic cmd_kind_e op_kind(input logic [NIB_W-1:0] op);
    case (op)
      4'b1000: op_kind = K_WR;
      4'b1001: op_kind = K_RD;
      4'b1011: op_kind = K_MODE;
      4'b1100: op_kind = K_CWW;
      4'b1101: op_kind = K_CWR;
      default: op_kind = K_NONE;
    endcase
  endfunction

  function automatic logic [CNT_W-1:0] kind_len(input cmd_kind_e k);
    case (k)
      K_WR, K_RD: kind_len = CNT_W'(1);
      K_MODE:     kind_len = CNT_W'(6);
      K_CWW:      kind_len = CNT_W'(5);
      K_CWR:      kind_len = CNT_W'(4);
      default:    kind_len = '0;
    endcase
  endfunction

  // Idle and reserved codes: upper bit set, not a defined opcode.
  function automatic logic op_quiet(input logic [NIB_W-1:0] op);
    op_quiet = op[NIB_W-1] && (op_kind(op) == K_NONE);
  endfunction
endpackage

// File: rtl/cfd_seq_ctrl.sv
module cfd_seq_ctrl
  import cfd_pkg::*;
(
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 sync_clr,
  input  logic                 clk_en,
  input  logic [NIB_W-1:0]     nib,
  output logic                 start,
  output logic                 take,
  output logic                 check,
  output logic                 seq_bad,
  output logic [IDX_W-1:0]     idx,
  output cmd_kind_e            frame_kind
);
  phase_e           phase_q, phase_n;
  logic [CNT_W-1:0] rem_q, rem_n;
  logic [IDX_W-1:0] idx_q, idx_n;
  cmd_kind_e        kind_q, kind_n;
  cmd_kind_e        dec;

  assign dec = op_kind(nib);

  always_comb begin
    start   = clk_en && (phase_q == PH_IDLE) && (dec != K_NONE);
    seq_bad = clk_en && (phase_q == PH_IDLE) && (dec == K_NONE) && !op_quiet(nib);
    take    = clk_en && (phase_q == PH_COLLECT);
    check   = clk_en && (phase_q == PH_CHECK);
  end

  always_comb begin
    phase_n = phase_q;
    rem_n   = rem_q;
    idx_n   = idx_q;
    kind_n  = kind_q;
    if (sync_clr) begin
      phase_n = PH_IDLE;
      rem_n   = '0;
      idx_n   = '0;
      kind_n  = K_NONE;
    end else if (start) begin
      phase_n = PH_COLLECT;
      rem_n   = kind_len(dec);
      idx_n   = '0;
      kind_n  = dec;
    end else if (take) begin
      rem_n = rem_q - CNT_W'(1);
      idx_n = idx_q + IDX_W'(1);
      if (rem_q == CNT_W'(1)) phase_n = PH_CHECK;
    end else if (check) begin
      phase_n = PH_IDLE;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      phase_q <= PH_IDLE;
      rem_q   <= '0;
      idx_q   <= '0;
      kind_q  <= K_NONE;
    end else begin
      phase_q <= phase_n;
      rem_q   <= rem_n;
      idx_q   <= idx_n;
      kind_q  <= kind_n;
    end
  end

  assign idx        = idx_q;
  assign frame_kind = kind_q;

  // R10
  freeze_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!clk_en && !sync_clr) |=> (phase_q == $past(phase_q)));

  // R1
  clr_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    sync_clr |=> (phase_q == PH_IDLE));

  // R11
  idx_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (phase_q == PH_COLLECT) |-> (int'(idx_q) < MAX_PAY));
endmodule

// File: rtl/cfd_payload_asm.sv
module cfd_payload_asm
  import cfd_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             sync_clr,
  input  logic             start,
  input  logic             take,
  input  logic [IDX_W-1:0] idx,
  input  logic [NIB_W-1:0] nib,
  output logic [PAY_W-1:0] payload,
  output logic [NIB_W-1:0] par_acc
);
  logic [NIB_W-1:0] slot_q [MAX_PAY];
  logic [NIB_W-1:0] par_q, par_n;

  for (genvar s = 0; s < MAX_PAY; s++) begin : g_slot
    logic [NIB_W-1:0] slot_n;
    always_comb begin
      slot_n = slot_q[s];
      if (sync_clr || start)                 slot_n = '0;
      else if (take && (idx == IDX_W'(s)))   slot_n = nib;
    end
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) slot_q[s] <= '0;
      else        slot_q[s] <= slot_n;
    end
    assign payload[s*NIB_W +: NIB_W] = slot_q[s];
  end

  always_comb begin
    par_n = par_q;
    if (sync_clr)   par_n = '0;
    else if (start) par_n = nib;
    else if (take)  par_n = par_q ^ nib;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) par_q <= '0;
    else        par_q <= par_n;
  end

  assign par_acc = par_q;

  // R1
  clr_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    sync_clr |=> (payload == '0 && par_acc == '0));

  // R11
  fresh_frame_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (start && !sync_clr) |=> (payload == '0));
endmodule

// File: rtl/cfd_result_stage.sv
module cfd_result_stage
  import cfd_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             sync_clr,
  input  logic             check,
  input  logic             seq_bad,
  input  logic [NIB_W-1:0] nib,
  input  logic [NIB_W-1:0] par_acc,
  input  cmd_kind_e        frame_kind,
  input  logic [PAY_W-1:0] frame_pay,
  output logic             vld,
  output logic             perr,
  output logic             serr,
  output cmd_kind_e        kind,
  output logic [PAY_W-1:0] pay
);
  logic             vld_q, vld_n, perr_q, perr_n, serr_q, serr_n;
  cmd_kind_e        kind_q, kind_n;
  logic [PAY_W-1:0] pay_q, pay_n;
  logic             par_ok;

  assign par_ok = (nib == par_acc);

  always_comb begin
    vld_n  = 1'b0;
    perr_n = 1'b0;
    serr_n = 1'b0;
    kind_n = kind_q;
    pay_n  = pay_q;
    if (sync_clr) begin
      kind_n = K_NONE;
      pay_n  = '0;
    end else begin
      serr_n = seq_bad;
      if (check) begin
        if (par_ok) begin
          vld_n  = 1'b1;
          kind_n = frame_kind;
          pay_n  = frame_pay;
        end else begin
          perr_n = 1'b1;
        end
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      vld_q  <= 1'b0;
      perr_q <= 1'b0;
      serr_q <= 1'b0;
      kind_q <= K_NONE;
      pay_q  <= '0;
    end else begin
      vld_q  <= vld_n;
      perr_q <= perr_n;
      serr_q <= serr_n;
      kind_q <= kind_n;
      pay_q  <= pay_n;
    end
  end

  assign vld  = vld_q;
  assign perr = perr_q;
  assign serr = serr_q;
  assign kind = kind_q;
  assign pay  = pay_q;

  // R9
  vld_perr_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(vld_q && perr_q));

  // R10
  vld_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    vld_q |=> !vld_q);

  // R9
  perr_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    perr_q |-> (pay_q == $past(pay_q) && kind_q == $past(kind_q)));
endmodule

// File: rtl/cmdbus_frame_decoder.sv
module cmdbus_frame_decoder
  import cfd_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              sync_clr,
  input  logic              clk_en,
  input  logic [NIB_W-1:0]  cmd_nib,
  output logic              cmd_vld,
  output logic [KIND_W-1:0] cmd_kind,
  output logic [PAY_W-1:0]  cmd_payload,
  output logic              err_par,
  output logic              err_seq
);
  logic             start, take, check, seq_bad;
  logic [IDX_W-1:0] idx;
  cmd_kind_e        frame_kind, kind_out;
  logic [PAY_W-1:0] frame_pay;
  logic [NIB_W-1:0] par_acc;

  cfd_seq_ctrl u_ctrl (
    .clk        (clk),
    .rst_n      (rst_n),
    .sync_clr   (sync_clr),
    .clk_en     (clk_en),
    .nib        (cmd_nib),
    .start      (start),
    .take       (take),
    .check      (check),
    .seq_bad    (seq_bad),
    .idx        (idx),
    .frame_kind (frame_kind)
  );

  cfd_payload_asm u_pay (
    .clk      (clk),
    .rst_n    (rst_n),
    .sync_clr (sync_clr),
    .start    (start),
    .take     (take),
    .idx      (idx),
    .nib      (cmd_nib),
    .payload  (frame_pay),
    .par_acc  (par_acc)
  );

  cfd_result_stage u_res (
    .clk        (clk),
    .rst_n      (rst_n),
    .sync_clr   (sync_clr),
    .check      (check),
    .seq_bad    (seq_bad),
    .nib        (cmd_nib),
    .par_acc    (par_acc),
    .frame_kind (frame_kind),
    .frame_pay  (frame_pay),
    .vld        (cmd_vld),
    .perr       (err_par),
    .serr       (err_seq),
    .kind       (kind_out),
    .pay        (cmd_payload)
  );

  assign cmd_kind = kind_out;

  // R7
  seq_src_chk: assert property (@(posedge clk) disable iff (!rst_n)
    err_seq |-> ($past(clk_en) && !$past(cmd_nib[NIB_W-1]) && !$past(sync_clr)));

  // R2
  kind_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
    cmd_vld |-> (cmd_kind != 3'd0 && cmd_kind <= 3'd5));
endmodule

// File: tb/cmdbus_frame_decoder_tb_top.sv
`timescale 1ns/1ps
module cmdbus_frame_decoder_tb_top;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        sync_clr = 1'b0;
  logic        clk_en = 1'b0;
  logic [3:0]  cmd_nib = 4'hA;
  logic        cmd_vld, err_par, err_seq;
  logic [2:0]  cmd_kind;
  logic [23:0] cmd_payload;

  int checks = 0;
  int errors = 0;
  bit cmp_on = 1'b0;
  string cur_req = "R1";

  always #2 clk = ~clk;

  cmdbus_frame_decoder dut_i (
    .clk(clk), .rst_n(rst_n), .sync_clr(sync_clr), .clk_en(clk_en),
    .cmd_nib(cmd_nib), .cmd_vld(cmd_vld), .cmd_kind(cmd_kind),
    .cmd_payload(cmd_payload), .err_par(err_par), .err_seq(err_seq)
  );

  // ---------------- behavioural reference model ----------------
  int          ms, rem, sl;
  logic [3:0]  acc;
  logic [23:0] bld;
  logic [2:0]  kb;
  logic        e_vld, e_perr, e_serr;
  logic [2:0]  e_kind;
  logic [23:0] e_pay;

  function automatic int plen(input logic [3:0] op);
    case (op)
      4'h8, 4'h9: return 1;   // R2
      4'hB:       return 6;   // R3
      4'hC:       return 5;   // R4
      4'hD:       return 4;   // R5
      default:    return 0;
    endcase
  endfunction

  function automatic logic [2:0] pkind(input logic [3:0] op);
    case (op)
      4'h8: return 3'd1; 4'h9: return 3'd2; 4'hB: return 3'd3;
      4'hC: return 3'd4; 4'hD: return 3'd5; default: return 3'd0;
    endcase
  endfunction

  always @(posedge clk) begin
    if (!rst_n) begin
      ms = 0; rem = 0; sl = 0; acc = 0; bld = 0; kb = 0;
      e_vld = 0; e_perr = 0; e_serr = 0; e_kind = 0; e_pay = 0;
    end else begin
      e_vld = 0; e_perr = 0; e_serr = 0;
      if (sync_clr) begin
        ms = 0; bld = 0; acc = 0; e_kind = 0; e_pay = 0;
      end else if (clk_en) begin
        case (ms)
          0: if (plen(cmd_nib) > 0) begin
               ms = 1; rem = plen(cmd_nib); sl = 0; acc = cmd_nib; bld = 0; kb = pkind(cmd_nib);
             end else if (cmd_nib < 4'h8) e_serr = 1;   // R7; R6 quiet otherwise
          1: begin
               bld[sl*4 +: 4] = cmd_nib; acc = acc ^ cmd_nib;   // R8 R11
               sl++; rem--;
               if (rem == 0) ms = 2;
             end
          default: begin
               if (cmd_nib == acc) begin e_vld = 1; e_kind = kb; e_pay = bld; end
               else e_perr = 1;                                  // R9
               ms = 0;                                           // R12
             end
        endcase
      end
    end
  end

  task automatic chk(input bit ok, input string what, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s actual=%0h expected=%0h", cur_req, what, act, exp);
    end
  endtask

  always @(negedge clk) begin
    if (cmp_on) begin
      chk(cmd_vld === e_vld, "cmd_vld", int'(cmd_vld), int'(e_vld));
      chk(err_par === e_perr, "err_par", int'(err_par), int'(e_perr));
      chk(err_seq === e_serr, "err_seq", int'(err_seq), int'(e_serr));
      chk(cmd_kind === e_kind, "cmd_kind", int'(cmd_kind), int'(e_kind));
      chk(cmd_payload === e_pay, "cmd_payload", int'(cmd_payload), int'(e_pay));
    end
  end

  // ---------------- stimulus ----------------
  task automatic put(input logic [3:0] n, input bit en, input bit clr = 1'b0);
    @(negedge clk);
    cmd_nib = n; clk_en = en; sync_clr = clr;
  endtask

  task automatic frame(input logic [3:0] op, input logic [23:0] pv,
                       input bit bad, input bit gaps);
    logic [3:0] p;
    p = op;
    put(op, 1);
    for (int i = 0; i < plen(op); i++) begin
      if (gaps && ($urandom % 2)) put(4'($urandom), 0);   // R10
      p = p ^ pv[i*4 +: 4];
      put(pv[i*4 +: 4], 1);
    end
    if (gaps && ($urandom % 2)) put(4'($urandom), 0);
    put(bad ? (p ^ 4'h1) : p, 1);
  endtask

  initial begin
    repeat (4) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R1 reset state
    cur_req = "R1";
    chk(cmd_vld == 0 && err_par == 0 && err_seq == 0, "pulses after reset", 0, 0);
    chk(cmd_kind == 0, "kind after reset", int'(cmd_kind), 0);
    chk(cmd_payload == 0, "payload after reset", int'(cmd_payload), 0);
    cmp_on = 1'b1;

    cur_req = "R2"; frame(4'h8, 24'h000005, 0, 0); frame(4'h9, 24'h00000C, 0, 0);
    cur_req = "R3"; frame(4'hB, 24'h3C5A96, 0, 0);
    cur_req = "R4"; frame(4'hC, 24'h012345, 0, 0);
    cur_req = "R5"; frame(4'hD, 24'h00FEDC, 0, 0);
    put(4'hA, 1); put(4'hA, 1);
    cur_req = "R6"; put(4'hA, 1); put(4'hE, 1); put(4'hF, 1); put(4'hA, 1); put(4'hA, 1);
    cur_req = "R7";
    for (int v = 0; v < 8; v++) begin put(4'(v), 1); put(4'hA, 1); end
    put(4'h3, 1); put(4'h0, 1); put(4'hA, 1);
    cur_req = "R8"; frame(4'hB, 24'hAEF0A1, 0, 0); put(4'hA, 1);
    cur_req = "R9"; frame(4'hC, 24'h0ABCDE, 1, 0); put(4'hA, 1); put(4'hA, 1);
    frame(4'h8, 24'h000007, 1, 0); put(4'hA, 1);
    cur_req = "R10"; frame(4'hD, 24'h004321, 0, 1); put(4'h2, 0); put(4'hA, 1);
    cur_req = "R11"; frame(4'h9, 24'h00000F, 0, 0); put(4'hA, 1);
    cur_req = "R12"; frame(4'h8, 24'h000001, 0, 0); frame(4'hD, 24'h009876, 0, 0);
    frame(4'h9, 24'h000002, 0, 0); put(4'hA, 1);
    // R1 clear in mid-payload, then clear on a correct parity slot
    cur_req = "R1";
    put(4'hB, 1); put(4'h1, 1); put(4'h2, 1, 1); put(4'hA, 1); put(4'hA, 1);
    put(4'h8, 1); put(4'h4, 1); put(4'hC, 1, 1); put(4'hA, 1); put(4'hA, 1);
    cur_req = "R12";
    for (int n = 0; n < 300; n++) begin
      logic [3:0] ops[5] = '{4'h8, 4'h9, 4'hB, 4'hC, 4'hD};
      int r = $urandom % 10;
      if (r < 7) frame(ops[$urandom % 5], 24'($urandom), ($urandom % 6) == 0, ($urandom % 3) == 0);
      else if (r < 9) put(4'($urandom), ($urandom % 4) != 0);
      else put(4'hA, 1, 1);
    end
    put(4'hA, 1); put(4'hA, 1); put(4'hA, 1);
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    errors++;
    $display("FAIL watchdog actual=hung expected=done");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule